// File: doc/BRIEF.md
# I2C Target Receive Engine with Programmable Clock Holds

This block is the receive side of an I2C target. It watches the open-drain SCL and SDA lines, recognises its own 7-bit or 10-bit address, captures written data bytes and answers each byte it takes part in with an acknowledge. Software can arm three hold points: after a matching address byte, after a received write byte, and after the acknowledge clock of any byte the target takes part in. At an armed point the block raises that point's interrupt flag and a shared stretch bit, then pulls SCL low. The host stays stalled until software has dealt with the byte.

While SCL is held, software reads the captured byte or the address outcome and picks ACK or NACK through a control bit. It then clears the flag and the stretch bit in either order. The bus is released only once both are clear. A STOP ends the transfer, drops the target-active status and discards any pending hold. The register port is a plain single-cycle write strobe with a combinational read. No data stream leaves the block, so the port has no valid/ready handshake and no back-pressure.

Top module: `i2c_tgt_hold`

## Requirements
- R1: With the address hold enable (control bit 0) set, the 8th falling SCL edge of a matching 7-bit address byte (own address in bits 7:1, R/W in bit 0) sets the address flag (status bit 0) and the stretch bit (status bit 3), and SCL is pulled low.
- R2: With the write hold enable (control bit 1) set, the 8th falling SCL edge of a data byte in a write transfer sets the write flag (status bit 1) and the stretch bit and pulls SCL low. The byte can be read at offset 4.
- R3: With the ack-time hold enable (control bit 2) set, the 9th falling SCL edge of every address or data byte the target takes part in sets the ack flag (status bit 2) and the stretch bit and pulls SCL low.
- R4: Writing 1 to a status bit among bits 3:0 clears it. SCL stays held until the flag that caused the hold and the stretch bit are both clear, whichever is cleared first.
- R5: In the 9th clock of an accepted address or write byte, SDA is pulled low unless control bit 4 (reply NACK) is set. The value used is the one present when SCL rises, so it may be changed during a hold. A byte the target does not accept is never acknowledged.
- R6: In 10-bit mode (control bit 3), a matching second address byte (equal to offset 2) gives an address hold when enabled, and sets target-active.
- R7: In 10-bit mode, a header byte 11110 + own bits 9:8 (offset 3, bits 1:0) + R/W=1 is accepted and held only while target-active is set. Otherwise it is NACKed with no hold.
- R8: In 10-bit mode, a matching header byte with R/W=0 is acknowledged but never causes an address hold.
- R9: Target-active (status bit 4) is set by an address match. It is cleared by STOP and by a non-matching address after a repeated START. STOP also clears all flags and the stretch bit.
- R10: The interrupt output is high exactly when some flag is set together with its enable.
- R11: After reset every register reads zero and neither SCL nor SDA is pulled.
- R12: Control (offset 0, bits 4:0) reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_pull_o | output | 1 | Pull SCL low (clock hold) |
| sda_pull_o | output | 1 | Pull SDA low (acknowledge) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps all eight combinations of the three hold enables over a full 7-bit write transfer. In each combination it predicts exactly which of the three points must stall the host, and alternates the order in which flag and stretch bit are cleared. A design that released SCL on a single clear would let the bench see SCL free while a bit was still set. A design that miscounted edges would hold at the wrong clock or acknowledge late. The 10-bit cases go after the asymmetric header rules: a design that held on a write header would stall where no hold is allowed, and one that accepted a read header without prior activity would acknowledge a transfer it had not been selected for. A NACK chosen during a hold, and a mismatching repeated START, check that the reply bit and the active status follow the bus and not stale state.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_OWNLO = 3'd2;
  localparam logic [REG_AW-1:0] OFS_OWNHI = 3'd3;
  localparam logic [REG_AW-1:0] OFS_RXD   = 3'd4;

  // hold-point index, also the status bit position of each flag
  localparam int unsigned HP_ADR = 0;
  localparam int unsigned HP_WR  = 1;
  localparam int unsigned HP_ACK = 2;
  localparam int unsigned N_HP   = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR1,
    PH_ADDR2,
    PH_DATA,
    PH_SKIP
  } phase_e;

  typedef struct packed {
    logic nack;    // bit 4
    logic ten;     // bit 3
    logic ack_en;  // bit 2
    logic wr_en;   // bit 1
    logic adr_en;  // bit 0
  } ctrl_t;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import i2c_tgt_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] own_lo,
  input  logic [1:0]        own_hi,
  output logic              hit7,
  output logic              hdr_hit,
  output logic              lo_hit,
  output logic              rw
);
  assign hit7    = (byte_i[7:1] == own_lo[6:0]);
  assign hdr_hit = (byte_i[7:3] == 5'b11110) && (byte_i[2:1] == own_hi);
  assign lo_hit  = (byte_i == own_lo);
  assign rw      = byte_i[0];
endmodule

// File: rtl/i2c_hold_ctrl.sv
module i2c_hold_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_HP-1:0] set_i,
  input  logic            clr_all,
  input  logic            w1c_en,
  input  logic [N_HP:0]   w1c_bits,
  output logic [N_HP-1:0] flag_o,
  output logic            stretch_o,
  output logic            hold_o
);
  for (genvar g = 0; g < N_HP; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flag_o[g] <= 1'b0;
      else if (clr_all)               flag_o[g] <= 1'b0;
      else if (set_i[g])              flag_o[g] <= 1'b1;
      else if (w1c_en && w1c_bits[g]) flag_o[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        stretch_o <= 1'b0;
    else if (clr_all)                  stretch_o <= 1'b0;
    else if (|set_i)                   stretch_o <= 1'b1;
    else if (w1c_en && w1c_bits[N_HP]) stretch_o <= 1'b0;
  end

  assign hold_o = stretch_o | (|flag_o);
endmodule

// File: rtl/i2c_tgt_hold.sv
module i2c_tgt_hold
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_o
);
  localparam int unsigned CW = $clog2(BYTE_W + 2);
  localparam logic [CW-1:0] N_DATA = CW'(BYTE_W);
  localparam logic [CW-1:0] N_ACK  = CW'(BYTE_W + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic hit7, hdr_hit, lo_hit, rw;

  ctrl_t             ctrl;
  logic [BYTE_W-1:0] own_lo, rxd, shreg;
  logic [1:0]        own_hi;
  logic [CW-1:0]     rcnt;
  phase_e            phase, nxt;
  logic              active, dir_rd, ack_drv, engaged;
  logic              nxt_active, nxt_dir, take_ack, eng, capture, want_adr, want_wr;
  logic              busy, byte_done, ack_done;
  logic [N_HP-1:0]   set_hp, flag;
  logic              stretch, hold;
  logic [2:0]        unused_wdata;

  assign unused_wdata = reg_wdata[7:5];

  i2c_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_addr_cmp u_cmp (
    .byte_i(shreg), .own_lo(own_lo), .own_hi(own_hi),
    .hit7(hit7), .hdr_hit(hdr_hit), .lo_hit(lo_hit), .rw(rw)
  );

  assign busy      = (phase != PH_IDLE) && !start_det && !stop_det;
  assign byte_done = busy && scl_fall && (rcnt == N_DATA);
  assign ack_done  = busy && scl_fall && (rcnt == N_ACK);

  // decision taken at the 8th falling edge
  always_comb begin
    nxt        = phase;
    nxt_active = active;
    nxt_dir    = dir_rd;
    take_ack   = 1'b0;
    eng        = 1'b0;
    capture    = 1'b0;
    want_adr   = 1'b0;
    want_wr    = 1'b0;
    unique case (phase)
      PH_ADDR1: begin
        if (!ctrl.ten) begin
          if (hit7) begin
            take_ack = 1'b1; eng = 1'b1; want_adr = 1'b1;
            nxt_active = 1'b1; nxt_dir = rw; nxt = PH_DATA;
          end else begin
            nxt_active = 1'b0; nxt = PH_SKIP;
          end
        end else if (hdr_hit && !rw) begin
          take_ack = 1'b1; eng = 1'b1; nxt = PH_ADDR2;
        end else if (hdr_hit && rw && active) begin
          take_ack = 1'b1; eng = 1'b1; want_adr = 1'b1;
          nxt_dir = 1'b1; nxt = PH_DATA;
        end else begin
          nxt_active = 1'b0; nxt = PH_SKIP;
        end
      end
      PH_ADDR2: begin
        if (lo_hit) begin
          take_ack = 1'b1; eng = 1'b1; want_adr = 1'b1;
          nxt_active = 1'b1; nxt_dir = 1'b0; nxt = PH_DATA;
        end else begin
          nxt_active = 1'b0; nxt = PH_SKIP;
        end
      end
      PH_DATA: begin
        eng = 1'b1;
        if (!dir_rd) begin
          take_ack = 1'b1; capture = 1'b1; want_wr = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      own_lo  <= '0;
      own_hi  <= '0;
      rxd     <= '0;
      shreg   <= '0;
      rcnt    <= '0;
      phase   <= PH_IDLE;
      active  <= 1'b0;
      dir_rd  <= 1'b0;
      ack_drv <= 1'b0;
      engaged <= 1'b0;
    end else begin
      if (reg_wr) begin
        unique case (reg_addr)
          OFS_CTRL:  ctrl   <= ctrl_t'(reg_wdata[4:0]);
          OFS_OWNLO: own_lo <= reg_wdata;
          OFS_OWNHI: own_hi <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (start_det) begin
        phase <= PH_ADDR1; rcnt <= '0; ack_drv <= 1'b0; engaged <= 1'b0;
      end else if (stop_det) begin
        phase <= PH_IDLE; rcnt <= '0; ack_drv <= 1'b0; engaged <= 1'b0;
        active <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && rcnt < N_ACK) begin
          rcnt <= rcnt + 1'b1;
          if (rcnt < N_DATA) shreg <= {shreg[BYTE_W-2:0], sda_s};
        end
        if (byte_done) begin
          phase   <= nxt;
          active  <= nxt_active;
          dir_rd  <= nxt_dir;
          ack_drv <= take_ack;
          engaged <= eng;
          if (capture) rxd <= shreg;
        end
        if (ack_done) begin
          rcnt <= '0; ack_drv <= 1'b0; engaged <= 1'b0;
        end
      end
    end
  end

  assign set_hp[HP_ADR] = byte_done & want_adr & ctrl.adr_en;
  assign set_hp[HP_WR]  = byte_done & want_wr & ctrl.wr_en;
  assign set_hp[HP_ACK] = ack_done & engaged & ctrl.ack_en;

  i2c_hold_ctrl u_hold (
    .clk(clk), .rst_n(rst_n), .set_i(set_hp), .clr_all(stop_det),
    .w1c_en(reg_wr && reg_addr == OFS_STAT), .w1c_bits(reg_wdata[N_HP:0]),
    .flag_o(flag), .stretch_o(stretch), .hold_o(hold)
  );

  assign scl_pull_o = hold;
  assign sda_pull_o = ack_drv & ~ctrl.nack;
  assign irq_o      = |(flag & {ctrl.ack_en, ctrl.wr_en, ctrl.adr_en});

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL:  reg_rdata = {3'b000, ctrl};
      OFS_STAT:  reg_rdata = {3'b000, active, stretch, flag};
      OFS_OWNLO: reg_rdata = own_lo;
      OFS_OWNHI: reg_rdata = {6'b0, own_hi};
      OFS_RXD:   reg_rdata = rxd;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_tgt_hold_chk.sv
module i2c_tgt_hold_chk
  import i2c_tgt_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            scl_pull,
  input logic            irq,
  input logic            reg_wr,
  input logic            stop_det,
  input logic            active,
  input logic            stretch,
  input logic [N_HP-1:0] flag,
  input ctrl_t           ctrl
);
  // R1
  a_r1_adr_flag_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[HP_ADR]) |-> $past(ctrl.adr_en) && stretch);
  // R2
  a_r2_wr_flag_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[HP_WR]) |-> $past(ctrl.wr_en) && stretch);
  // R3
  a_r3_ack_flag_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[HP_ACK]) |-> $past(ctrl.ack_en) && stretch);
  // R4: a hold ends only through a register write or a STOP
  a_r4_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |-> $past(reg_wr) || $past(stop_det));
  // R10
  a_r10_irq_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> irq);
  // R9
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !active && !scl_pull);
endmodule

bind i2c_tgt_hold i2c_tgt_hold_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_pull(scl_pull_o), .irq(irq_o),
  .reg_wr(reg_wr), .stop_det(stop_det), .active(active),
  .stretch(stretch), .flag(flag), .ctrl(ctrl)
);

// File: tb/i2c_tgt_hold_test.sv
module i2c_tgt_hold_test;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl_low = 1'b0;
  logic host_sda_low = 1'b0;
  logic scl_bus, sda_bus;
  logic scl_pull, sda_pull, irq;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign scl_bus = !(host_scl_low || scl_pull);
  assign sda_bus = !(host_sda_low || sda_pull);

  i2c_tgt_hold uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic scl_up;
    host_scl_low = 1'b0;
    while (!scl_bus) @(negedge clk);
    cyc(T);
  endtask

  task automatic bus_start;
    host_sda_low = 1'b1; cyc(T);
    host_scl_low = 1'b1; cyc(T);
  endtask

  task automatic bus_rstart;
    host_sda_low = 1'b0; cyc(T);
    scl_up;
    host_sda_low = 1'b1; cyc(T);
    host_scl_low = 1'b1; cyc(T);
  endtask

  task automatic bus_stop;
    host_sda_low = 1'b1; cyc(T);
    scl_up;
    host_sda_low = 1'b0; cyc(T);
  endtask

  task automatic send8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      host_sda_low = ~b[i]; cyc(T);
      scl_up;
      host_scl_low = 1'b1; cyc(T);
    end
  endtask

  task automatic ack_clk(output logic a);
    host_sda_low = 1'b0; cyc(T);
    scl_up;
    a = sda_bus;
    host_scl_low = 1'b1; cyc(T);
  endtask

  // clears flag bit idx and stretch bit in the chosen order (R4)
  task automatic release_hold(input int idx, input bit flag_first);
    wreg(3'd1, flag_first ? 8'(1 << idx) : 8'h08);
    cyc(3);
    chk("R4 still held after one clear", scl_pull, 1);
    wreg(3'd1, flag_first ? 8'h08 : 8'(1 << idx));
    cyc(3);
    chk("R4 released after both clears", scl_pull, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic a;
    logic [7:0] data;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);

    // R11 reset state
    for (int r = 0; r < 5; r++) begin
      rreg(3'(r), d);
      chk("R11 register reset", d, 0);
    end
    chk("R11 scl pull", scl_pull, 0);
    chk("R11 sda pull", sda_pull, 0);
    chk("R11 irq", irq, 0);

    wreg(3'd2, 8'h2A);

    // sweep all hold-enable combinations over a 7-bit write transfer
    for (int en = 0; en < 8; en++) begin
      logic [2:0] e;
      e = 3'(en);
      data = 8'hA5 ^ 8'(en * 17);
      wreg(3'd0, {5'b0, e});
      rreg(3'd0, d);
      chk("R12 control readback", d, {5'b0, e});

      bus_start;
      send8(8'h54);
      chk("R1 address hold", scl_pull, e[0]);
      rreg(3'd1, d);
      chk("R1 address flag and stretch", {d[3], d[0]}, {e[0], e[0]});
      chk("R9 active after match", d[4], 1);
      chk("R10 irq at address hold", irq, e[0]);
      if (e[0]) release_hold(0, en[0]);
      ack_clk(a);
      chk("R5 address ACK", a, 0);
      chk("R3 ack hold after address", scl_pull, e[2]);
      if (e[2]) begin
        chk("R10 irq at ack hold", irq, 1);
        release_hold(2, !en[0]);
      end

      send8(data);
      chk("R2 write hold", scl_pull, e[1]);
      rreg(3'd1, d);
      chk("R2 write flag", d[1], e[1]);
      rreg(3'd4, d);
      chk("R2 captured byte", d, data);
      if (e[1]) release_hold(1, en[1]);
      ack_clk(a);
      chk("R5 data ACK", a, 0);
      chk("R3 ack hold after data", scl_pull, e[2]);
      if (e[2]) release_hold(2, en[1]);

      bus_stop;
      rreg(3'd1, d);
      chk("R9 status after STOP", d, 0);
    end

    // R5 NACK chosen while held
    wreg(3'd0, 8'h01);
    bus_start;
    send8(8'h54);
    chk("R1 held for NACK choice", scl_pull, 1);
    wreg(3'd0, 8'h11);
    release_hold(0, 1'b1);
    ack_clk(a);
    chk("R5 NACK chosen during hold", a, 1);
    bus_stop;

    // R5/R9 mismatching address
    wreg(3'd0, 8'h07);
    bus_start;
    send8(8'h56);
    chk("R9 no hold on mismatch", scl_pull, 0);
    ack_clk(a);
    chk("R5 mismatch not acknowledged", a, 1);
    rreg(3'd1, d);
    chk("R9 inactive on mismatch", d, 0);
    bus_stop;

    // R9 repeated START with a non-matching address clears active
    wreg(3'd0, 8'h00);
    bus_start;
    send8(8'h54);
    ack_clk(a);
    rreg(3'd1, d);
    chk("R9 active before repeated START", d[4], 1);
    bus_rstart;
    send8(8'h56);
    ack_clk(a);
    chk("R5 NACK after repeated START mismatch", a, 1);
    rreg(3'd1, d);
    chk("R9 active cleared by mismatch", d[4], 0);
    bus_stop;

    // 10-bit addressing, own address 0x2B5
    wreg(3'd2, 8'hB5);
    wreg(3'd3, 8'h02);
    wreg(3'd0, 8'h09);
    bus_start;
    send8(8'hF4);
    chk("R8 no hold on write header", scl_pull, 0);
    ack_clk(a);
    chk("R8 write header acknowledged", a, 0);
    send8(8'hB5);
    chk("R6 hold on low byte", scl_pull, 1);
    rreg(3'd1, d);
    chk("R6 flag and active", {d[4], d[0]}, 2'b11);
    release_hold(0, 1'b0);
    ack_clk(a);
    chk("R6 low byte acknowledged", a, 0);
    bus_rstart;
    send8(8'hF5);
    chk("R7 hold on read header while active", scl_pull, 1);
    release_hold(0, 1'b1);
    ack_clk(a);
    chk("R7 read header acknowledged", a, 0);
    bus_stop;

    bus_start;
    send8(8'hF5);
    chk("R7 no hold on read header when inactive", scl_pull, 0);
    ack_clk(a);
    chk("R7 read header refused when inactive", a, 1);
    bus_stop;
    rreg(3'd1, d);
    chk("R9 status after final STOP", d, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule